// File: doc/BRIEF.md
# ADC Result Monitor and Interrupt Logic

This block sits after a converter's decimation filter. It watches the stream of signed 16-bit results, each marked by a one-cycle valid strobe, and turns that stream into counts, a running sum and one interrupt line. Four event sources can drive the interrupt:

- a result counter that fires after a programmed number of results;
- a threshold counter that rises while results stay above a programmable level and falls or clears when they drop below it;
- the rising edge of an asynchronous overrange input;
- a plain per-result ready event.

A 32-bit accumulator sums the sign-extended results when it is enabled.

All configuration arrives as ports from the surrounding control logic. The interrupt is sticky: the selected source sets it, and a clear pulse removes it. The count outputs and the accumulator value are registered and readable at any time.

Top module: `adc_result_monitor`

## Requirements
- R1: After reset, `res_cnt_o`, `thr_cnt_o` and `acc_o` are zero and `irq_o` is low.
- R2: Each cycle with `res_valid_i` high increments `res_cnt_o`. A valid result that finds the count equal to (or above) `res_limit_i` reloads the count to zero and raises the result-counter event, so with limit L the event comes on every (L+1)-th result.
- R3: A valid result that is signed-greater than `thr_level_i` increments `thr_cnt_o`. If the count already equals (or exceeds) `thr_limit_i`, the count reloads to zero and the threshold event is raised instead.
- R4: Two cases leave `thr_cnt_o` unchanged: a valid result exactly equal to `thr_level_i`, and any cycle without `res_valid_i`.
- R5: With `thr_clr_mode_i` = 0, a valid result below the threshold decrements `thr_cnt_o`, which holds at zero rather than underflowing.
- R6: With `thr_clr_mode_i` = 1, a valid result below the threshold clears `thr_cnt_o` to zero.
- R7: While `acc_en_i` is high, every valid result is sign-extended and added to `acc_o`. While it is low, `acc_o` holds.
- R8: `acc_o` wraps modulo 2^32. `acc_clr_i` zeroes it on the next edge and takes priority over an add in the same cycle.
- R9: `ovr_i` passes through a two-flop synchronizer. Only its rising edge is an event: it sets the interrupt on the third clock edge after `ovr_i` rises, and a level held high does not set it again.
- R10: `irq_sel_i` picks the source: 0 = result counter, 1 = threshold counter, 2 = overrange edge, 3 = every valid result. Events from unselected sources do not affect `irq_o`.
- R11: `irq_o` is set on the edge after a selected event and stays high until `irq_clr_i` is sampled high. An event in the same cycle as the clear wins, and `irq_o` stays set.
- R12: `cnt_clr_i` zeroes both counters on the next edge, overriding any count or reload in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result strobe |
| res_data_i | input | 16 | Signed conversion result |
| thr_level_i | input | 16 | Signed threshold level |
| res_limit_i | input | 8 | Result counter limit |
| thr_limit_i | input | 8 | Threshold counter limit |
| thr_clr_mode_i | input | 1 | 0: decrement when below, 1: clear when below |
| cnt_clr_i | input | 1 | Clear both counters |
| acc_en_i | input | 1 | Accumulator enable |
| acc_clr_i | input | 1 | Accumulator synchronous clear |
| ovr_i | input | 1 | Asynchronous fast-overrange flag |
| irq_sel_i | input | 2 | Interrupt source select |
| irq_clr_i | input | 1 | Interrupt clear pulse |
| res_cnt_o | output | 8 | Result counter value |
| thr_cnt_o | output | 8 | Threshold counter value |
| acc_o | output | 32 | Accumulator value |
| irq_o | output | 1 | Sticky interrupt |

## Verification
Accumulator wrap is the hardest case to reach through the ports. Crossing 2^32 upward from zero would take over 65,000 maximum results. The bench instead adds -1 to a cleared sum to land on all-ones, then adds +2 to cross back through zero. That exercises both directions of the modulo wrap within a few results.

The threshold counter's floor and its reload are reached with short hand-built sequences against a small limit. The threshold runs in a mix of positive and negative levels, so the signed compare is tested rather than an unsigned one.

The overrange path is timed edge by edge. After the interrupt is cleared, `ovr_i` is held high, so that re-triggering on a level would be caught.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
  localparam int unsigned NUM_SRC = 4;
  typedef enum logic [1:0] {
    SRC_RES_CNT = 2'd0,
    SRC_THR_CNT = 2'd1,
    SRC_OVR     = 2'd2,
    SRC_READY   = 2'd3
  } irq_src_e;
endpackage

// File: rtl/adc_mon_wrap_cnt.sv
module adc_mon_wrap_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      if (cnt_q >= limit_i) begin
        cnt_d  = '0;
        wrap_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (dec_i && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_wrap_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == '0);
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && !clr_i && cnt_o == '0) |=> cnt_o == '0);
  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/adc_mon_accum.sv
module adc_mon_accum #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int unsigned EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] acc_q, data_ext;

  assign data_ext = {{EXT_W{data_i[DATA_W-1]}}, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= acc_q + data_ext;
  end

  assign acc_o = acc_q;

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_i && !clr_i) |=> $stable(acc_o));
endmodule

// File: rtl/adc_mon_ovr_sync.sv
module adc_mon_ovr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/adc_mon_irq_gen.sv
module adc_mon_irq_gen
  import adc_mon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  irq_src_e           sel_i,
  input  logic               clr_i,
  output logic               irq_o
);
  logic set, irq_q;

  assign set = evt_i[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set)   irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> !irq_o);
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && evt_i == '0) |=> !irq_o);
endmodule

// File: rtl/adc_result_monitor.sv
module adc_result_monitor
  import adc_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [DATA_W-1:0] thr_level_i,
  input  logic [CNT_W-1:0]  res_limit_i,
  input  logic [CNT_W-1:0]  thr_limit_i,
  input  logic              thr_clr_mode_i,
  input  logic              cnt_clr_i,
  input  logic              acc_en_i,
  input  logic              acc_clr_i,
  input  logic              ovr_i,
  input  logic [1:0]        irq_sel_i,
  input  logic              irq_clr_i,
  output logic [CNT_W-1:0]  res_cnt_o,
  output logic [CNT_W-1:0]  thr_cnt_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic              irq_o
);
  logic above, below;
  logic res_wrap, thr_wrap, ovr_rise;
  logic [NUM_SRC-1:0] evt;

  // signed compare; equality is neither above nor below
  assign above = res_valid_i && ($signed(res_data_i) > $signed(thr_level_i));
  assign below = res_valid_i && ($signed(res_data_i) < $signed(thr_level_i));

  adc_mon_wrap_cnt #(.CNT_W(CNT_W)) u_res_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (res_valid_i),
    .dec_i   (1'b0),
    .clr_i   (cnt_clr_i),
    .limit_i (res_limit_i),
    .cnt_o   (res_cnt_o),
    .wrap_o  (res_wrap)
  );

  adc_mon_wrap_cnt #(.CNT_W(CNT_W)) u_thr_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (above),
    .dec_i   (below && !thr_clr_mode_i),
    .clr_i   (cnt_clr_i || (below && thr_clr_mode_i)),
    .limit_i (thr_limit_i),
    .cnt_o   (thr_cnt_o),
    .wrap_o  (thr_wrap)
  );

  adc_mon_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .add_i  (res_valid_i && acc_en_i),
    .clr_i  (acc_clr_i),
    .data_i (res_data_i),
    .acc_o  (acc_o)
  );

  adc_mon_ovr_sync #(.STAGES(SYNC_N)) u_ovr_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ovr_i),
    .rise_o  (ovr_rise)
  );

  always_comb begin
    evt = '0;
    evt[SRC_RES_CNT] = res_wrap;
    evt[SRC_THR_CNT] = thr_wrap;
    evt[SRC_OVR]     = ovr_rise;
    evt[SRC_READY]   = res_valid_i;
  end

  adc_mon_irq_gen u_irq_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .sel_i  (irq_src_e'(irq_sel_i)),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  a_r4_equal_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_data_i == thr_level_i && !cnt_clr_i) |=> $stable(thr_cnt_o));
  a_r4_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i && !cnt_clr_i) |=> $stable(res_cnt_o) && $stable(thr_cnt_o));
  a_r6_below_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below && thr_clr_mode_i) |=> thr_cnt_o == '0);
endmodule

// File: tb/adc_result_monitor_test.sv
`timescale 1ns/1ps
module adc_result_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] data = '0;
  logic [15:0] thr = '0;
  logic [7:0]  res_lim = 8'd3;
  logic [7:0]  thr_lim = 8'd2;
  logic        mode = 1'b0;
  logic        cnt_clr = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_clr = 1'b0;
  logic        ovr = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        irq_clr = 1'b0;
  logic [7:0]  res_cnt, thr_cnt;
  logic [31:0] acc;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_result_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(valid), .res_data_i(data),
    .thr_level_i(thr), .res_limit_i(res_lim), .thr_limit_i(thr_lim),
    .thr_clr_mode_i(mode), .cnt_clr_i(cnt_clr), .acc_en_i(acc_en),
    .acc_clr_i(acc_clr), .ovr_i(ovr), .irq_sel_i(sel), .irq_clr_i(irq_clr),
    .res_cnt_o(res_cnt), .thr_cnt_o(thr_cnt), .acc_o(acc), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk); valid = 1'b1; data = d;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic pulse_cnt_clr();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 res_cnt", res_cnt, 0);
    chk("R1 thr_cnt", thr_cnt, 0);
    chk("R1 acc", acc, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_result_counter();
    sel = 2'd0; res_lim = 8'd3;
    send(16'd1); send(16'd2); send(16'd3);
    chk("R2 count 3", res_cnt, 3);
    chk("R2 no irq before limit", irq, 0);
    @(negedge clk);
    chk("R4 idle holds res_cnt", res_cnt, 3);
    send(16'd4);
    chk("R2 reload", res_cnt, 0);
    chk("R2 irq on wrap", irq, 1);
    @(negedge clk); @(negedge clk);
    chk("R11 sticky", irq, 1);
    pulse_irq_clr();
    chk("R11 cleared", irq, 0);
  endtask

  task automatic t_threshold();
    sel = 2'd1; thr = 16'd100; thr_lim = 8'd2; mode = 1'b0;
    pulse_cnt_clr();
    send(16'd200);  chk("R3 above inc", thr_cnt, 1);
    send(16'd100);  chk("R4 equal holds", thr_cnt, 1);
    send(16'd50);   chk("R5 below dec", thr_cnt, 0);
    send(16'd50);   chk("R5 floor at zero", thr_cnt, 0);
    chk("R10 result wrap ignored when sel=1", irq, 0);
    send(16'd200); send(16'd200);
    chk("R3 count 2", thr_cnt, 2);
    chk("R3 no irq yet", irq, 0);
    send(16'd200);
    chk("R3 reload", thr_cnt, 0);
    chk("R3 irq on wrap", irq, 1);
    pulse_irq_clr();
    thr = 16'hFFF6; // -10
    send(16'hFFFB); chk("R3 signed above", thr_cnt, 1);
    send(16'hFFEC); chk("R5 signed below dec", thr_cnt, 0);
    mode = 1'b1;
    send(16'd5); send(16'd5);
    chk("R3 count before clear", thr_cnt, 2);
    send(16'h8000);
    chk("R6 below clears", thr_cnt, 0);
    mode = 1'b0;
  endtask

  task automatic t_accum();
    sel = 2'd0;
    @(negedge clk); acc_clr = 1'b1;
    @(negedge clk); acc_clr = 1'b0;
    chk("R8 clear", acc, 0);
    acc_en = 1'b1;
    send(16'd1000); send(16'hF448); // -3000
    chk("R7 signed sum", acc, 32'hFFFFF830);
    send(16'h8000);
    chk("R7 most negative", acc, 32'hFFFF7830);
    acc_en = 1'b0;
    send(16'd5);
    chk("R7 disabled holds", acc, 32'hFFFF7830);
    acc_en = 1'b1;
    @(negedge clk); acc_clr = 1'b1;
    @(negedge clk); acc_clr = 1'b0;
    send(16'hFFFF);
    chk("R8 wrap below zero", acc, 32'hFFFFFFFF);
    send(16'd2);
    chk("R8 wrap through zero", acc, 32'd1);
    @(negedge clk); acc_clr = 1'b1; valid = 1'b1; data = 16'd77;
    @(negedge clk); acc_clr = 1'b0; valid = 1'b0;
    chk("R8 clear wins over add", acc, 0);
    acc_en = 1'b0;
    pulse_irq_clr();
  endtask

  task automatic t_overrange();
    sel = 2'd2;
    pulse_irq_clr();
    @(negedge clk); ovr = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 not yet after two edges", irq, 0);
    @(negedge clk);
    chk("R9 set on third edge", irq, 1);
    pulse_irq_clr();
    repeat (4) @(negedge clk);
    chk("R9 held level no retrigger", irq, 0);
    ovr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 fall no event", irq, 0);
    ovr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 second rise", irq, 1);
    ovr = 1'b0;
    repeat (3) @(negedge clk);
    pulse_irq_clr();
  endtask

  task automatic t_ready_and_priority();
    sel = 2'd3;
    send(16'd9);
    chk("R10 ready source", irq, 1);
    @(negedge clk); irq_clr = 1'b1; valid = 1'b1; data = 16'd9;
    @(negedge clk); irq_clr = 1'b0; valid = 1'b0;
    chk("R11 set wins over clear", irq, 1);
    pulse_irq_clr();
    chk("R11 clear after", irq, 0);
  endtask

  task automatic t_cnt_clear();
    sel = 2'd0; res_lim = 8'd50; thr_lim = 8'd50; thr = 16'd0;
    pulse_cnt_clr();
    send(16'd10); send(16'd10);
    chk("R12 pre res", res_cnt, 2);
    chk("R12 pre thr", thr_cnt, 2);
    @(negedge clk); cnt_clr = 1'b1; valid = 1'b1; data = 16'd10;
    @(negedge clk); cnt_clr = 1'b0; valid = 1'b0;
    chk("R12 res cleared", res_cnt, 0);
    chk("R12 thr cleared", thr_cnt, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_result_counter();
    t_threshold();
    t_accum();
    t_overrange();
    t_ready_and_priority();
    t_cnt_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule